// File: doc/BRIEF.md
# Grouped Event Selector with Conflict Check

This block is the allocation front end of a cache performance monitor. Events sit in a grid: eight groups (columns), each with many codes (rows). A request names an event as a 12-bit value, laid out as two hex digits of code followed by one hex digit of group. A group can hold only one active code at a time. The block keeps a code selector per group and a reference count per group. It steers the pulse output of the selected group into one of four general 32-bit counters, or into a dedicated 64-bit cycle counter.

Software-side logic (not part of this block) issues one request per cycle. A request either allocates an event onto a counter or releases a counter. Each request receives a registered response on the following cycle, and the response carries an error flag. A request whose group is held by a different code is rejected and changes nothing. A request whose group is held by the same code shares that group's pulse stream. The special value 0x0FE is outside the group scheme and claims the cycle counter. The cache logic that turns each group's programmed code into a pulse is outside this block.

Top module: `grp_event_alloc`

## Requirements
- R1: After reset, every counter value is 0, no counter and no cycle counter is busy, all group enables are 0, and rsp_valid_o is 0.
- R2: An allocation of a non-cycle event onto a free counter whose group is idle succeeds. After it, that group's enable is 1 and the counter is busy.
- R3: Event bits [11:4] are the code and bits [3:0] are the group digit. The code appears on grp_code_o lane g, which is bits [8g+7:8g]. A group digit of 8 to 15 is rejected, unless the whole value is 0x0FE.
- R4: An allocation naming an enabled group that holds a different code is answered with an error. All group enables, codes and busy flags stay unchanged.
- R5: An allocation naming an enabled group that holds the same code succeeds. Every counter on that group counts the same pulses.
- R6: A release frees the counter named by req_cnt_i. The group stays enabled until the last counter that references it is released. A released counter keeps its value and stops counting.
- R7: An allocation clears its counter to 0. After that, a busy counter adds one for each clock edge at which its group's bit of grp_evt_i is 1.
- R8: An allocation onto a busy counter is rejected. A release of an idle counter is rejected.
- R9: The value 0x0FE ignores req_cnt_i and claims the cycle counter. The cycle counter is cleared on allocation and adds one on every edge while busy. An allocation while it is busy is rejected. A release while it is idle is rejected.
- R10: rsp_valid_o is 1 exactly in the cycle after each accepted request edge. rsp_err_o is 1 only together with rsp_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_free_i | input | 1 | 0 = allocate, 1 = release |
| req_cnt_i | input | CIDX_W (2) | General counter index |
| req_event_i | input | 12 | Event value, code then group digit |
| grp_evt_i | input | 8 | Per-group event pulse from the cache |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Response error flag |
| grp_en_o | output | 8 | Group selector enable |
| grp_code_o | output | 64 | Programmed code per group, 8 bits per lane |
| cnt_busy_o | output | NUM_CNT (4) | General counter allocated |
| cnt_val_o | output | NUM_CNT*CNT_W (128) | General counter values, counter k at lane k |
| cyc_busy_o | output | 1 | Cycle counter allocated |
| cyc_val_o | output | CYC_W (64) | Cycle counter value |

## Verification
The assertions take for granted that there is at most one request per cycle and that every input has a known value outside reset. They also assume the requester never relies on an error response to change state. The bench drives all inputs on the falling edge. It holds req_valid_i high for exactly one cycle per request and raises group pulses only between requests, so that each counter total follows directly from the number of edges it was driven. Both the table walk and the directed tests keep req_cnt_i inside the four counters, so range rejection stays outside the checked behaviour.

// File: rtl/gea_pkg.sv
// Shared constants and types for the grouped event selector.
// Assumes the fixed 12-bit event layout: 8-bit code, 4-bit group digit.
package gea_pkg;
    localparam int NUM_GROUPS = 8;
    localparam int GRP_W      = 3;
    localparam int CODE_W     = 8;
    localparam int EVT_W      = 12;
    localparam logic [EVT_W-1:0] CYCLE_EVT = 12'h0FE;

    // Outcome of decoding one request against current state.
    typedef struct packed {
        logic              err;
        logic              is_cyc;
        logic [GRP_W-1:0]  grp;
        logic [CODE_W-1:0] code;
    } decision_t;
endpackage

// File: rtl/gea_ctrl.sv
// Request decoder: splits the event value and decides accept or reject
// from the current allocation state. Purely combinational.
// Assumes at most one request is presented per cycle.
module gea_ctrl
    import gea_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CIDX_W  = 2
) (
    input  logic                         req_free_i,
    input  logic [CIDX_W-1:0]            req_cnt_i,
    input  logic [EVT_W-1:0]             req_event_i,
    input  logic [NUM_CNT-1:0]           cnt_busy_i,
    input  logic                         cyc_busy_i,
    input  logic [NUM_GROUPS-1:0]        grp_en_i,
    input  logic [NUM_GROUPS*CODE_W-1:0] grp_code_i,
    output decision_t                    dec_o
);
    logic [3:0]        gdig;
    logic              idx_ok;
    logic              tgt_busy;
    logic [CODE_W-1:0] lane_code;

    // Field split and lookups of the named counter and group.
    always_comb begin
        gdig      = req_event_i[3:0];
        idx_ok    = (32'(req_cnt_i) < NUM_CNT);
        tgt_busy  = idx_ok ? cnt_busy_i[req_cnt_i] : 1'b0;
        lane_code = grp_code_i[int'(gdig[2:0])*CODE_W +: CODE_W];
    end

    // Accept/reject decision for allocate and release.
    always_comb begin
        dec_o.code   = req_event_i[EVT_W-1:4];
        dec_o.grp    = gdig[2:0];
        dec_o.is_cyc = (req_event_i == CYCLE_EVT);
        if (dec_o.is_cyc) begin
            dec_o.err = req_free_i ? !cyc_busy_i : cyc_busy_i;
        end else if (req_free_i) begin
            dec_o.err = !idx_ok || !tgt_busy;
        end else begin
            dec_o.err = !idx_ok || gdig[3] || tgt_busy ||
                        (grp_en_i[gdig[2:0]] && (lane_code != dec_o.code));
        end
    end
endmodule

// File: rtl/gea_group_slot.sv
// One group selector: holds the programmed code and counts how many
// counters reference the group. The group is enabled while references exist.
// Assumes take and drop are never requested in the same cycle.
module gea_group_slot #(
    parameter int NUM_CNT = 4,
    parameter int CODE_W  = 8,
    localparam int REF_W  = $clog2(NUM_CNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              drop_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              en_o,
    output logic [CODE_W-1:0] code_o
);
    logic [REF_W-1:0] refs;

    // Reference count and code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refs   <= '0;
            code_o <= '0;
        end else begin
            if (take_i) begin
                refs   <= refs + REF_W'(1);
                code_o <= code_i;
            end else if (drop_i) begin
                refs   <= refs - REF_W'(1);
            end
        end
    end

    // Group is live while any counter references it.
    assign en_o = (refs != '0);
endmodule

// File: rtl/gea_counter.sv
// Plain up-counter with synchronous clear; clear wins over increment.
// Assumes wrap-around on overflow is acceptable to the consumer.
module gea_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o
);
    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)       val_o <= '0;
        else if (clear_i) val_o <= '0;
        else if (inc_i)   val_o <= val_o + W'(1);
    end
endmodule

// File: rtl/grp_event_alloc.sv
// Grouped event selector top: decodes requests, keeps the counter-to-group
// table, programs group selectors and steers group pulses into counters.
// Assumes one request per cycle; responses follow one cycle later.
module grp_event_alloc
    import gea_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int CYC_W   = 64,
    localparam int CIDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid_i,
    input  logic                         req_free_i,
    input  logic [CIDX_W-1:0]            req_cnt_i,
    input  logic [EVT_W-1:0]             req_event_i,
    input  logic [NUM_GROUPS-1:0]        grp_evt_i,
    output logic                         rsp_valid_o,
    output logic                         rsp_err_o,
    output logic [NUM_GROUPS-1:0]        grp_en_o,
    output logic [NUM_GROUPS*CODE_W-1:0] grp_code_o,
    output logic [NUM_CNT-1:0]           cnt_busy_o,
    output logic [NUM_CNT*CNT_W-1:0]     cnt_val_o,
    output logic                         cyc_busy_o,
    output logic [CYC_W-1:0]             cyc_val_o
);
    decision_t        dec;
    logic             ok;
    logic             alloc_gen;
    logic             free_gen;
    logic             alloc_cyc;
    logic             free_cyc;
    logic [GRP_W-1:0] cnt_grp [NUM_CNT];
    logic [GRP_W-1:0] free_grp;

    gea_ctrl #(
        .NUM_CNT (NUM_CNT),
        .CIDX_W  (CIDX_W)
    ) u_ctrl (
        .req_free_i  (req_free_i),
        .req_cnt_i   (req_cnt_i),
        .req_event_i (req_event_i),
        .cnt_busy_i  (cnt_busy_o),
        .cyc_busy_i  (cyc_busy_o),
        .grp_en_i    (grp_en_o),
        .grp_code_i  (grp_code_o),
        .dec_o       (dec)
    );

    // Qualified actions of the current request.
    always_comb begin
        ok        = req_valid_i && !dec.err;
        alloc_gen = ok && !req_free_i && !dec.is_cyc;
        free_gen  = ok &&  req_free_i && !dec.is_cyc;
        alloc_cyc = ok && !req_free_i &&  dec.is_cyc;
        free_cyc  = ok &&  req_free_i &&  dec.is_cyc;
        free_grp  = cnt_grp[req_cnt_i];
    end

    // Response register: one strobe per request, error flag alongside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_err_o   <= req_valid_i && dec.err;
        end
    end

    // Cycle counter ownership flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc_busy_o <= 1'b0;
        else if (alloc_cyc) cyc_busy_o <= 1'b1;
        else if (free_cyc)  cyc_busy_o <= 1'b0;
    end

    gea_counter #(.W(CYC_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (alloc_cyc),
        .inc_i   (cyc_busy_o),
        .val_o   (cyc_val_o)
    );

    // Per-group selectors.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic take;
        logic drop;
        assign take = alloc_gen && (dec.grp == GRP_W'(g));
        assign drop = free_gen  && (free_grp == GRP_W'(g));
        gea_group_slot #(
            .NUM_CNT (NUM_CNT),
            .CODE_W  (CODE_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .take_i (take),
            .drop_i (drop),
            .code_i (dec.code),
            .en_o   (grp_en_o[g]),
            .code_o (grp_code_o[g*CODE_W +: CODE_W])
        );
    end

    // Per-counter allocation entry and steered counter.
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        logic hit;
        logic clr;
        logic inc;
        assign hit = (req_cnt_i == CIDX_W'(k));
        assign clr = alloc_gen && hit;
        assign inc = cnt_busy_o[k] && grp_evt_i[cnt_grp[k]];

        // Allocation table entry for counter k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_busy_o[k] <= 1'b0;
                cnt_grp[k]    <= '0;
            end else if (clr) begin
                cnt_busy_o[k] <= 1'b1;
                cnt_grp[k]    <= dec.grp;
            end else if (free_gen && hit) begin
                cnt_busy_o[k] <= 1'b0;
            end
        end

        gea_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clr),
            .inc_i   (inc),
            .val_o   (cnt_val_o[k*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/gea_checker.sv
// Property checker for grp_event_alloc, attached by bind.
// Assumes one request per cycle and known inputs outside reset.
module gea_checker #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int CYC_W   = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid_i,
    input logic                     rsp_valid_o,
    input logic                     rsp_err_o,
    input logic [7:0]               grp_en_o,
    input logic [63:0]              grp_code_o,
    input logic [NUM_CNT-1:0]       cnt_busy_o,
    input logic [NUM_CNT*CNT_W-1:0] cnt_val_o,
    input logic                     cyc_busy_o,
    input logic [CYC_W-1:0]         cyc_val_o
);
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);                               // R10
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);                             // R10
    AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> rsp_valid_o);                                 // R10
    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_err_o) |-> ($stable(grp_en_o) && $stable(grp_code_o)
            && $stable(cnt_busy_o) && $stable(cyc_busy_o)));        // R4
    AST_EN_RISE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_en_o & ~$past(grp_en_o)) != 8'd0) |-> (rsp_valid_o && !rsp_err_o)); // R2
    AST_NO_ORPHAN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cnt_busy_o) == 0) |-> (grp_en_o == 8'd0));      // R6
    AST_GROUPS_LE_USERS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grp_en_o) <= $countones(cnt_busy_o));           // R5
    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_busy_o |=> (cyc_val_o == $past(cyc_val_o) + {{(CYC_W-1){1'b0}}, 1'b1})); // R9

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_idle
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_busy_o[k] |=> (cnt_busy_o[k] || $stable(cnt_val_o[k*CNT_W +: CNT_W]))); // R6
    end
endmodule

bind grp_event_alloc gea_checker #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .CYC_W   (CYC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .grp_en_o    (grp_en_o),
    .grp_code_o  (grp_code_o),
    .cnt_busy_o  (cnt_busy_o),
    .cnt_val_o   (cnt_val_o),
    .cyc_busy_o  (cyc_busy_o),
    .cyc_val_o   (cyc_val_o)
);

// File: tb/grp_event_alloc_tb.sv
// Self-checking bench: table walk of requests, then directed tests.
module grp_event_alloc_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_free = 1'b0;
    logic [1:0]   req_cnt = '0;
    logic [11:0]  req_event = '0;
    logic [7:0]   grp_evt = '0;
    logic         rsp_valid;
    logic         rsp_err;
    logic [7:0]   grp_en;
    logic [63:0]  grp_code;
    logic [3:0]   cnt_busy;
    logic [127:0] cnt_val;
    logic         cyc_busy;
    logic [63:0]  cyc_val;
    int           checks = 0;
    int           fails = 0;

    always #10 clk = ~clk;

    grp_event_alloc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_free_i  (req_free),
        .req_cnt_i   (req_cnt),
        .req_event_i (req_event),
        .grp_evt_i   (grp_evt),
        .rsp_valid_o (rsp_valid),
        .rsp_err_o   (rsp_err),
        .grp_en_o    (grp_en),
        .grp_code_o  (grp_code),
        .cnt_busy_o  (cnt_busy),
        .cnt_val_o   (cnt_val),
        .cyc_busy_o  (cyc_busy),
        .cyc_val_o   (cyc_val)
    );

    // Entry: {free, counter, event, expected error}
    localparam logic [15:0] VEC [15] = '{
        {1'b0, 2'd0, 12'h123, 1'b0},
        {1'b0, 2'd1, 12'h453, 1'b1},
        {1'b0, 2'd1, 12'h123, 1'b0},
        {1'b0, 2'd0, 12'h010, 1'b1},
        {1'b0, 2'd2, 12'h019, 1'b1},
        {1'b0, 2'd2, 12'h0FE, 1'b0},
        {1'b0, 2'd3, 12'h0FE, 1'b1},
        {1'b0, 2'd2, 12'h7A0, 1'b0},
        {1'b1, 2'd3, 12'h000, 1'b1},
        {1'b1, 2'd0, 12'h000, 1'b0},
        {1'b0, 2'd3, 12'h453, 1'b1},
        {1'b1, 2'd1, 12'h000, 1'b0},
        {1'b0, 2'd3, 12'h453, 1'b0},
        {1'b1, 2'd0, 12'h0FE, 1'b0},
        {1'b1, 2'd0, 12'h0FE, 1'b1}
    };
    localparam string VEC_TAG [15] = '{
        "R2", "R4", "R5", "R8", "R3", "R9", "R9", "R2",
        "R8", "R6", "R6", "R6", "R6", "R9", "R9"
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic fr, input logic [1:0] c, input logic [11:0] e,
                          input logic exp_err, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_free  = fr;
        req_cnt   = c;
        req_event = e;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 rsp_valid", 64'(rsp_valid), 64'd1);
        check(tag, 64'(rsp_err), 64'(exp_err));
    endtask

    task automatic pulse(input int g, input int n);
        @(negedge clk);
        grp_evt = 8'(1 << g);
        repeat (n) @(negedge clk);
        grp_evt = '0;
    endtask

    function automatic logic [63:0] cval(input int k);
        return 64'(cnt_val[k*32 +: 32]);
    endfunction

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 grp_en", 64'(grp_en), 64'd0);
        check("R1 busy", 64'({cyc_busy, cnt_busy}), 64'd0);
        check("R1 cnt", 64'(|cnt_val), 64'd0);

        for (int i = 0; i < 15; i++)
            do_req(VEC[i][15], VEC[i][14:13], VEC[i][12:1], VEC[i][0], VEC_TAG[i]);

        // State now: c2 on group 0 code 7A, c3 on group 3 code 45
        check("R2 grp_en", 64'(grp_en), 64'h09);
        check("R3 lane0 code", 64'(grp_code[7:0]), 64'h7A);
        check("R3 lane3 code", 64'(grp_code[31:24]), 64'h45);
        check("R6 busy set", 64'(cnt_busy), 64'hC);
        check("R9 cycle freed", 64'(cyc_busy), 64'd0);

        pulse(0, 5);
        pulse(3, 3);
        pulse(5, 2);
        check("R7 c2 count", cval(2), 64'd5);
        check("R7 c3 count", cval(3), 64'd3);
        check("R7 c0 idle", cval(0), 64'd0);
        check("R7 c1 idle", cval(1), 64'd0);

        do_req(1'b0, 2'd0, 12'h453, 1'b0, "R5 share");
        pulse(3, 4);
        check("R5 c0 shared", cval(0), 64'd4);
        check("R5 c3 shared", cval(3), 64'd7);

        do_req(1'b1, 2'd3, 12'h000, 1'b0, "R6 free c3");
        check("R6 group kept", 64'(grp_en[3]), 64'd1);
        pulse(3, 2);
        check("R6 c0 counts", cval(0), 64'd6);
        check("R6 c3 held", cval(3), 64'd7);

        do_req(1'b1, 2'd0, 12'h000, 1'b0, "R6 free c0");
        check("R6 group off", 64'(grp_en[3]), 64'd0);
        pulse(3, 1);
        check("R6 c0 held", cval(0), 64'd6);

        do_req(1'b0, 2'd0, 12'h7A0, 1'b0, "R7 realloc");
        check("R7 cleared", cval(0), 64'd0);

        do_req(1'b0, 2'd1, 12'h0FE, 1'b0, "R9 cycle alloc");
        check("R9 index ignored", 64'(cnt_busy[1]), 64'd0);
        check("R9 cycle busy", 64'(cyc_busy), 64'd1);
        repeat (10) @(negedge clk);
        do_req(1'b1, 2'd1, 12'h0FE, 1'b0, "R9 cycle free");
        check("R9 cycle count", cyc_val, 64'd12);
        repeat (3) @(negedge clk);
        check("R9 cycle held", cyc_val, 64'd12);
        check("R10 quiet", 64'(rsp_valid), 64'd0);

        // R1 reset in mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 busy after reset", 64'({cyc_busy, cnt_busy}), 64'd0);
        check("R1 grp_en after reset", 64'(grp_en), 64'd0);
        check("R1 cnt after reset", 64'(|cnt_val), 64'd0);
        check("R1 cyc after reset", cyc_val, 64'd0);

        summary();
        $finish;
    end
endmodule